// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block drains a ring of transmit descriptors kept in system memory and turns each referenced packet buffer into a byte stream for the MAC side. Software sets up the ring's base address and its number of entries. It hands descriptors to the engine by clearing their done flag and then advancing a producer (CPU) index register. The engine owns a consumer (DMA) index. It works through descriptors while that index trails the producer index and the engine is enabled.

For each descriptor the engine reads three words over a single-request memory port: the buffer pointer, the length word and the port-tag word. It then fetches the buffer one 32-bit word at a time and presents its bytes on a valid/ready stream, tagged with a destination port number and marked on the final byte. After the final byte is accepted, it can write the length word back with the done flag set and advance its index. Clearing the enable bit lets the descriptor in flight finish before the engine goes idle.

Top module: `txq_dma`

## Requirements
- R1: After reset the DMA index reads 0, the busy flag (config bit 1) is 0, the ring-count register reads 2^IW, and neither out_valid nor mem_req is asserted.
- R2: Registers sit at word addresses 0 ring base, 1 ring count, 2 CPU index, 3 DMA index (read-only), 4 config (bit 0 enable, bit 1 busy read-only, bit 6 write-back enable), 5 index reset. A descriptor is started only when enable is 1 and the DMA index differs from the CPU index, and work stops once they are equal.
- R3: Descriptor n occupies four words at ring base + 16*n. Word 0 (offset 0) is the buffer byte address. Word 1 (offset 4) holds the length in bits 29:16. Word 3 (offset 12) holds the destination port in bits 26:24.
- R4: The bytes of a descriptor come out in ascending address order from the buffer address, each byte taken little-endian from its memory word (address a is bits 8*(a mod 4)+7 : 8*(a mod 4)). Exactly length bytes are sent, each carrying out_port. out_last is set only on the final byte. Outputs hold steady while out_ready is low.
- R5: When config bit 6 is set, after the final byte word 1 is rewritten with bit 31 set and all its other bits unchanged. When bit 6 is clear, memory is not written. Either way the DMA index then advances.
- R6: The DMA index wraps from ring count - 1 to 0.
- R7: A descriptor of length 0 is completed (and written back if enabled) without any stream byte.
- R8: When enable is cleared during a descriptor, busy stays 1 until that descriptor completes and then drops. No further descriptor starts.
- R9: Writing address 5 with bit 0 set clears the DMA index. A write with bit 0 clear leaves it alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a descriptor |
| out_port | output | 3 | Destination port of the current descriptor |

## Verification
The main transfer is exercised with buffers that start at each of the four byte offsets within a word. Lengths of 1, 5, 6, 9 and 40 cross word boundaries at different points, which separates a wrong byte lane or a missed refetch from a correct stream. Runs alternate among a ready signal that is always high, one with periodic gaps and one mostly low, and among memory acknowledgements with and without stalls, so that a dropped or repeated byte under backpressure shows up against the reference queue. Separate phases contrast write-back on and off, a zero length entry, a producer index that wraps past the ring end, and a disable issued mid-packet. Together they tell index and hand-back errors apart from stream errors.

// File: rtl/txq_dma.sv
module txq_dma #(
  parameter int IW = 8,
  parameter int LW = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic [2:0]  out_port
);
  localparam logic [IW:0] FULL_RING = (IW+1)'(1) << IW;

  typedef enum logic [2:0] {S_IDLE, S_PTR, S_LEN, S_TAG, S_FETCH, S_SEND, S_DONE} st_t;
  st_t state;

  logic [31:0]   ring_base, ptr, w1, word;
  logic [IW:0]   ring_cnt;
  logic [IW-1:0] cpu_idx, dma_idx, nxt_idx;
  logic [LW-1:0] rem;
  logic [2:0]    port;
  logic          en, wb_en, busy, idx_clr, advance;
  logic [31:0]   desc;

  assign busy    = state != S_IDLE;
  assign idx_clr = reg_wr && reg_addr == 3'd5 && reg_wdata[0];
  assign advance = state == S_DONE && (!wb_en || mem_ack);
  assign nxt_idx = ({1'b0, dma_idx} + 1'b1 == ring_cnt) ? '0 : dma_idx + 1'b1;
  assign desc    = ring_base + {{(28-IW){1'b0}}, dma_idx, 4'b0000};

  assign mem_req   = state inside {S_PTR, S_LEN, S_TAG, S_FETCH} || (state == S_DONE && wb_en);
  assign mem_we    = state == S_DONE;
  assign mem_wdata = w1 | 32'h8000_0000;
  assign out_valid = state == S_SEND;
  assign out_data  = word[{ptr[1:0], 3'b000} +: 8];
  assign out_last  = rem == LW'(1);
  assign out_port  = port;

  always_comb begin
    case (state)
      S_PTR:          mem_addr = desc;
      S_LEN, S_DONE:  mem_addr = desc + 32'd4;
      S_TAG:          mem_addr = desc + 32'd12;
      S_FETCH:        mem_addr = {ptr[31:2], 2'b00};
      default:        mem_addr = '0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ring_base;
      3'd1:    reg_rdata = 32'(ring_cnt);
      3'd2:    reg_rdata = 32'(cpu_idx);
      3'd3:    reg_rdata = 32'(dma_idx);
      3'd4:    reg_rdata = {25'd0, wb_en, 4'd0, busy, en};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_base <= '0;
      ring_cnt  <= FULL_RING;
      cpu_idx   <= '0;
      en        <= 1'b0;
      wb_en     <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: ring_base <= reg_wdata;
        3'd1: ring_cnt  <= reg_wdata[IW:0];
        3'd2: cpu_idx   <= reg_wdata[IW-1:0];
        3'd4: begin en <= reg_wdata[0]; wb_en <= reg_wdata[6]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dma_idx <= '0;
    else if (idx_clr) dma_idx <= '0;
    else if (advance) dma_idx <= nxt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      w1    <= '0;
      word  <= '0;
      rem   <= '0;
      port  <= '0;
    end else begin
      case (state)
        S_IDLE:  if (en && dma_idx != cpu_idx) state <= S_PTR;
        S_PTR:   if (mem_ack) begin ptr <= mem_rdata; state <= S_LEN; end
        S_LEN:   if (mem_ack) begin w1 <= mem_rdata; rem <= mem_rdata[16 +: LW]; state <= S_TAG; end
        S_TAG:   if (mem_ack) begin
                   port  <= mem_rdata[26:24];
                   state <= (rem == '0) ? S_DONE : S_FETCH;
                 end
        S_FETCH: if (mem_ack) begin word <= mem_rdata; state <= S_SEND; end
        S_SEND:  if (out_ready) begin
                   if (rem == LW'(1)) state <= S_DONE;
                   else begin
                     rem <= rem - 1'b1;
                     ptr <= ptr + 32'd1;
                     if (ptr[1:0] == 2'b11) state <= S_FETCH;
                   end
                 end
        S_DONE:  if (advance) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_dma_chk.sv
module txq_dma_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          en,
  input logic          idx_clr,
  input logic [IW-1:0] dma_idx,
  input logic          mem_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic [2:0]    out_port
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !mem_req));

  p_no_start_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en) |=> !busy);

  p_hold_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_port)));

  p_gap_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dma_idx) && !$past(idx_clr)) |-> (dma_idx == $past(dma_idx) + 1'b1 || dma_idx == '0));

  p_idx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> dma_idx == '0);
endmodule

bind txq_dma txq_dma_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .en(en), .idx_clr(idx_clr),
  .dma_idx(dma_idx), .mem_req(mem_req), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .out_port(out_port)
);

// File: tb/txq_dma_tb.sv
module txq_dma_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        out_valid, out_ready = 0, out_last;
  logic [7:0]  out_data;
  logic [2:0]  out_port;

  txq_dma u_dut (.*);

  always #5 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [11:0] exp_q [$];
  int checks = 0, fails = 0, cyc = 0, ncnt = 0;
  int ready_mode = 0;
  bit stall = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    ncnt++;
    if (mem_ack) mem_ack = 0;
    else if (rst_n && mem_req && (!stall || ncnt % 3 != 0)) begin
      mem_ack = 1;
      if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
      else mem_rdata = mem[mem_addr[11:2]];
    end
    case (ready_mode)
      0: out_ready = 1;
      1: out_ready = (ncnt % 3 != 0);
      default: out_ready = (ncnt % 5 == 0);
    endcase
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R4", "unexpected byte", {out_last, out_port, out_data}, 0);
      else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({out_last, out_port, out_data} == e, "R4", "stream {last,port,byte}", {out_last, out_port, out_data}, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R2", "watchdog cycles", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  localparam int BASE = 32'h100;

  task automatic set_desc(input int n, input int ptr, input int len, input int port);
    mem[(BASE + 16*n)/4]     = ptr;
    mem[(BASE + 16*n)/4 + 1] = 32'h4000_0000 | (len << 16) | 32'h12;
    mem[(BASE + 16*n)/4 + 3] = (port << 24) | 32'hF8A5_00A5 & ~32'h0700_0000;
    for (int i = 0; i < len; i++) begin
      int a = ptr + i;
      mem[a/4][8*(a%4) +: 8] = 8'((a * 7 + 3) ^ n);
    end
  endtask

  task automatic expect_desc(input int n);
    int ptr = mem[(BASE + 16*n)/4];
    int len = (mem[(BASE + 16*n)/4 + 1] >> 16) & 16'h3FFF;
    logic [2:0] port = mem[(BASE + 16*n)/4 + 3][26:24];
    for (int i = 0; i < len; i++) begin
      int a = ptr + i;
      exp_q.push_back({(i == len - 1), port, mem[a/4][8*(a%4) +: 8]});
    end
  endtask

  task automatic wait_idx(input int target);
    logic [31:0] d, c;
    for (int k = 0; k < 3000; k++) begin
      rd(3, d); rd(4, c);
      if (d == target && c[1] == 0) break;
    end
  endtask

  function automatic logic [31:0] w1_of(input int n);
    return mem[(BASE + 16*n)/4 + 1];
  endfunction

  logic [31:0] v, old1;

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !mem_req, "R1", "valid/req after reset", {out_valid, mem_req}, 0);
    rd(3, v); chk(v == 0, "R1", "dma index", v, 0);
    rd(4, v); chk(v[1] == 0, "R1", "busy", v[1], 0);
    rd(1, v); chk(v == 256, "R1", "ring count", v, 256);

    wr(0, BASE); wr(1, 4);
    rd(0, v); chk(v == BASE, "R2", "base readback", v, BASE);
    rd(1, v); chk(v == 4, "R2", "count readback", v, 4);

    // Phase A: R3 R4 R5 - three descriptors, unaligned buffers, stalls
    set_desc(0, 32'h400, 5, 1);
    set_desc(1, 32'h443, 1, 7);
    set_desc(2, 32'h481, 9, 3);
    expect_desc(0); expect_desc(1); expect_desc(2);
    stall = 1; ready_mode = 1;
    wr(4, 32'h41); wr(2, 3);
    wait_idx(3);
    rd(3, v); chk(v == 3, "R2", "index reaches cpu index", v, 3);
    chk(exp_q.size() == 0, "R4", "all bytes sent", exp_q.size(), 0);
    for (int n = 0; n < 3; n++)
      chk(w1_of(n) == (32'hC000_0012 | ((n == 0 ? 5 : n == 1 ? 1 : 9) << 16)), "R5", "word1 done write-back", w1_of(n), 32'hC000_0012 | ((n == 0 ? 5 : n == 1 ? 1 : 9) << 16));

    // Phase B: R6 R7 - wrap 3 -> 0 -> 1, zero length at 0
    stall = 0; ready_mode = 0;
    set_desc(3, 32'h502, 6, 2);
    set_desc(0, 32'h580, 0, 5);
    expect_desc(3);
    wr(2, 1);
    wait_idx(1);
    rd(3, v); chk(v == 1, "R6", "index after wrap", v, 1);
    chk(exp_q.size() == 0, "R7", "no bytes left/added", exp_q.size(), 0);
    chk(w1_of(0) == 32'hC000_0012, "R7", "zero length done", w1_of(0), 32'hC000_0012);
    chk(w1_of(3) == 32'hC006_0012, "R6", "wrapped desc done", w1_of(3), 32'hC006_0012);

    // Phase C: R5 write-back disabled
    set_desc(1, 32'h600, 3, 6);
    expect_desc(1);
    old1 = w1_of(1);
    wr(4, 32'h01); wr(2, 2);
    wait_idx(2);
    rd(3, v); chk(v == 2, "R5", "index advances without write-back", v, 2);
    chk(w1_of(1) == old1, "R5", "word1 untouched", w1_of(1), old1);
    chk(exp_q.size() == 0, "R4", "bytes sent", exp_q.size(), 0);

    // Phase D: R8 disable mid-packet
    set_desc(2, 32'h700, 40, 4);
    set_desc(3, 32'h740, 4, 0);
    expect_desc(2);
    old1 = w1_of(3);
    ready_mode = 2;
    wr(4, 32'h41); wr(2, 0);
    for (int k = 0; k < 500 && !out_valid; k++) @(negedge clk);
    wr(4, 32'h40);
    rd(4, v); chk(v[1] == 1, "R8", "busy while in flight", v[1], 1);
    for (int k = 0; k < 3000; k++) begin rd(4, v); if (v[1] == 0) break; end
    chk(v[1] == 0, "R8", "busy drops", v[1], 0);
    chk(exp_q.size() == 0, "R8", "in-flight bytes finished", exp_q.size(), 0);
    repeat (20) @(negedge clk);
    rd(3, v); chk(v == 3, "R8", "no further descriptor", v, 3);
    chk(w1_of(3) == old1, "R8", "next desc not done", w1_of(3), old1);
    chk(w1_of(2) == 32'hC028_0012, "R5", "long desc done", w1_of(2), 32'hC028_0012);

    // Phase E: R9 index reset, R2 disabled start
    ready_mode = 0;
    wr(5, 32'h2);
    rd(3, v); chk(v == 3, "R9", "bit0 clear leaves index", v, 3);
    wr(5, 32'h1);
    rd(3, v); chk(v == 0, "R9", "index cleared", v, 0);
    wr(2, 2);
    repeat (20) @(negedge clk);
    rd(3, v); chk(v == 0, "R2", "disabled engine stays", v, 0);
    rd(4, v); chk(v[1] == 0, "R2", "disabled not busy", v[1], 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule